// File: doc/BRIEF.md
# SD Card Identification State Machine

This block is the card-side controller for bus identification. It takes commands that have already been decoded, each as a 6-bit index, a 32-bit argument and a one-cycle valid strobe. It decides how the card state changes and which response the card must send. Responses are only requested here: a one-cycle strobe with a kind code tells the response serializer to send the operating-conditions word, the identification number, the newly published relative address or the card-specific data. The contents of those registers are outside this block. The operating-conditions word comes in as a constant input.

The card starts idle. A host operating-conditions query is valid only straight after an application-escape command whose address field is zero. A compatible card whose power-up is complete moves to ready. A card whose voltage window does not overlap the host's is parked in the inactive state for good. From ready, the identification command moves the card to the identification state. The address command then publishes a nonzero relative address taken from an internal LFSR and moves the card to stand-by. In stand-by the card may republish a fresh address any number of times. A card-data request is answered only when its address matches the latest published address.

Top module: `card_ident_fsm`

## Requirements
- R1: After reset, state_o is 0 (idle), rca_o is 0 and rsp_valid_o is low. The state codes are idle 0, ready 1, identification 2, stand-by 3 and inactive 4.
- R2: Command 41 is acted on only if the valid command directly before it was command 55 with argument bits 31:16 equal to 0. Any other command 41 gives no response and leaves the state unchanged. The escape is used up by the next valid command, whatever that command is.
- R3: An accepted command 41 in idle gives a response of kind 1 (operating conditions) one cycle after the strobe. The voltage window is argument and OCR bits 23:15. If those windows overlap and OCR bit 31 is set, the card moves to ready. If they overlap and bit 31 is clear, it stays idle.
- R4: An accepted command 41 whose voltage window does not overlap the OCR window still responds with kind 1, and moves the card to inactive. In inactive every command, command 0 included, gives no response and leaves the state unchanged, until reset.
- R5: Command 2 in ready gives a kind 2 response (identification number) and moves the card to the identification state. In any other state, command 2 has no effect.
- R6: Command 3 in the identification state gives a kind 3 response (relative address), loads the new address into rca_o and moves the card to stand-by. Command 3 in idle or ready has no effect.
- R7: Command 3 in stand-by gives a kind 3 response, and the new address replaces the stored one. After that, the old address no longer selects the card.
- R8: Each published address is the next state of a 16-bit LFSR. The LFSR is seeded to 16'hACE1 at reset and is not cleared by command 0. Its next value is {s[14:0], ^(s & 16'hB400)}. It advances only when an address is published, and a published address is never 0.
- R9: Command 9 in stand-by gives a kind 4 response (card data) only when argument bits 31:16 equal rca_o. Otherwise it gives no response and leaves the state unchanged.
- R10: Command 0 in any state except inactive returns the card to idle, clears rca_o to 0 and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe marking a decoded command |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| ocr_i | input | 32 | Card operating-conditions word (bit 31 power-up done, bits 23:15 voltage window) |
| rsp_valid_o | output | 1 | Response request strobe |
| rsp_kind_o | output | 3 | Response kind: 0 none, 1 OCR, 2 CID, 3 RCA, 4 CSD |
| rca_o | output | 16 | Currently stored relative address |
| state_o | output | 3 | Current card state code |

## Verification
The state machine is driven with a full identification sequence. Interleaved with it are commands sent in the wrong state, an escape command carrying a nonzero address, and a query not preceded by the escape. These show whether each transition is guarded by the state, by the escape flag or by the argument. Further directed runs compare a matching with a mismatching card-data address before and after a republish, which separates the old address from the new one. A busy card and an incompatible card show the three outcomes of the query. Command 0 is sent both in stand-by and in inactive, which tells the sticky inactive state apart from an ordinary reset to idle.

// File: rtl/card_ident_pkg.sv
package card_ident_pkg;
  localparam int IDX_W = 6;
  localparam int ARG_W = 32;
  localparam int RCA_W = 16;

  localparam logic [IDX_W-1:0] CMD_RESET = 6'd0;
  localparam logic [IDX_W-1:0] CMD_CID   = 6'd2;
  localparam logic [IDX_W-1:0] CMD_RCA   = 6'd3;
  localparam logic [IDX_W-1:0] CMD_CSD   = 6'd9;
  localparam logic [IDX_W-1:0] CMD_OPC   = 6'd41;
  localparam logic [IDX_W-1:0] CMD_APP   = 6'd55;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_IDENT = 3'd2,
    ST_STBY  = 3'd3,
    ST_INACT = 3'd4
  } card_state_e;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_OCR  = 3'd1,
    RSP_CID  = 3'd2,
    RSP_RCA  = 3'd3,
    RSP_CSD  = 3'd4
  } rsp_kind_e;
endpackage

// File: rtl/card_rca_gen.sv
module card_rca_gen #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] lfsr_q;

  assign nxt_o = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (step_i) lfsr_q <= nxt_o;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(lfsr_q)); // R8
endmodule

// File: rtl/card_app_tracker.sv
module card_app_tracker
  import card_ident_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [RCA_W-1:0] cmd_addr_i,
  input  logic             clr_i,
  output logic             app_o
);
  logic app_q;

  // escape lasts for exactly the next valid command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          app_q <= 1'b0;
    else if (clr_i)       app_q <= 1'b0;
    else if (cmd_valid_i) app_q <= (cmd_idx_i == CMD_APP) && (cmd_addr_i == '0);
  end

  assign app_o = app_q;

  AST_APP_ONLY_AFTER_55: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(app_q) |-> $past(cmd_valid_i) && $past(cmd_idx_i) == CMD_APP); // R2
endmodule

// File: rtl/card_ident_fsm.sv
module card_ident_fsm
  import card_ident_pkg::*;
#(
  parameter logic [RCA_W-1:0] RCA_SEED = 16'hACE1,
  parameter logic [RCA_W-1:0] RCA_TAPS = 16'hB400,
  parameter int VOLT_LSB = 15,
  parameter int VOLT_MSB = 23,
  parameter int BUSY_BIT = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic [ARG_W-1:0] ocr_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_kind_o,
  output logic [RCA_W-1:0] rca_o,
  output logic [2:0]       state_o
);
  localparam int ADDR_LSB = ARG_W - RCA_W;

  card_state_e      state_q, state_d;
  rsp_kind_e        rsp_q, rsp_d;
  logic [RCA_W-1:0] rca_q, rca_new;
  logic             step, clr_rca, app, volt_ok;
  logic [RCA_W-1:0] cmd_addr;

  assign cmd_addr = cmd_arg_i[ARG_W-1:ADDR_LSB];
  assign volt_ok  = |(cmd_arg_i[VOLT_MSB:VOLT_LSB] & ocr_i[VOLT_MSB:VOLT_LSB]);

  card_app_tracker u_app (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_idx_i  (cmd_idx_i),
    .cmd_addr_i (cmd_addr),
    .clr_i      (state_q == ST_INACT),
    .app_o      (app)
  );

  card_rca_gen #(.W(RCA_W), .SEED(RCA_SEED), .TAPS(RCA_TAPS)) u_rca (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .nxt_o (rca_new)
  );

  always_comb begin
    state_d = state_q;
    rsp_d   = RSP_NONE;
    step    = 1'b0;
    clr_rca = 1'b0;
    if (cmd_valid_i && state_q != ST_INACT) begin
      if (cmd_idx_i == CMD_RESET) begin
        state_d = ST_IDLE;
        clr_rca = 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (cmd_idx_i == CMD_OPC && app) begin
            rsp_d = RSP_OCR;
            if (!volt_ok)              state_d = ST_INACT;
            else if (ocr_i[BUSY_BIT])  state_d = ST_READY;
          end
          ST_READY: if (cmd_idx_i == CMD_CID) begin
            rsp_d   = RSP_CID;
            state_d = ST_IDENT;
          end
          ST_IDENT: if (cmd_idx_i == CMD_RCA) begin
            rsp_d   = RSP_RCA;
            step    = 1'b1;
            state_d = ST_STBY;
          end
          ST_STBY: begin
            if (cmd_idx_i == CMD_RCA) begin
              rsp_d = RSP_RCA;
              step  = 1'b1;
            end else if (cmd_idx_i == CMD_CSD && cmd_addr == rca_q) begin
              rsp_d = RSP_CSD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rsp_q   <= RSP_NONE;
      rca_q   <= '0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
      if (clr_rca)   rca_q <= '0;
      else if (step) rca_q <= rca_new;
    end
  end

  assign rsp_valid_o = (rsp_q != RSP_NONE);
  assign rsp_kind_o  = rsp_q;
  assign rca_o       = rca_q;
  assign state_o     = state_q;

  AST_RSP_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(cmd_valid_i)); // R2
  AST_OCR_NEEDS_APP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_kind_o == RSP_OCR |-> $past(app) && $past(state_q) == ST_IDLE); // R3
  AST_INACT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_INACT |=> state_q == ST_INACT && !rsp_valid_o); // R4
  AST_CID_FROM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_kind_o == RSP_CID |-> $past(state_q) == ST_READY && state_q == ST_IDENT); // R5
  AST_RCA_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_kind_o == RSP_RCA |-> state_q == ST_STBY); // R6
  AST_RCA_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STBY |-> rca_q != '0); // R8
  AST_CSD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_kind_o == RSP_CSD |-> $past(cmd_addr) == rca_q); // R9
  AST_CMD0_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_idx_i == CMD_RESET && state_q != ST_INACT
    |=> state_q == ST_IDLE && rca_q == '0 && !rsp_valid_o); // R10
endmodule

// File: tb/card_ident_fsm_bench.sv
module card_ident_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam logic [31:0] OCR_OK = 32'h80FF_8000;
  localparam logic [31:0] VW     = 32'h00FF_8000;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [2:0]  st;
    logic [2:0]  kind;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{6'd41, VW,           3'd0, 3'd0}, // R2 no escape
    '{6'd55, 32'h0,        3'd0, 3'd0},
    '{6'd2,  32'h0,        3'd0, 3'd0}, // R5 ignored in idle, uses escape
    '{6'd41, VW,           3'd0, 3'd0}, // R2 escape used up
    '{6'd55, 32'h1234_0000,3'd0, 3'd0},
    '{6'd41, VW,           3'd0, 3'd0}, // R2 nonzero address
    '{6'd55, 32'h0,        3'd0, 3'd0},
    '{6'd41, VW,           3'd1, 3'd1}, // R3 ready
    '{6'd3,  32'h0,        3'd1, 3'd0}, // R6 ignored in ready
    '{6'd2,  32'h0,        3'd2, 3'd2}, // R5
    '{6'd2,  32'h0,        3'd2, 3'd0}, // R5 ignored in ident
    '{6'd3,  32'h0,        3'd3, 3'd3}, // R6
    '{6'd0,  32'h0,        3'd0, 3'd0}  // R10
  };

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0, ocr = OCR_OK;
  logic        rsp_valid;
  logic [2:0]  rsp_kind, state;
  logic [15:0] rca;

  int errors = 0, checks = 0;
  logic [15:0] m_lfsr = 16'hACE1, m_rca = '0, rca_a;

  card_ident_fsm u_card_ident_fsm (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_idx_i(cmd_idx),
    .cmd_arg_i(cmd_arg), .ocr_i(ocr), .rsp_valid_o(rsp_valid),
    .rsp_kind_o(rsp_kind), .rca_o(rca), .state_o(state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [2:0] st, input logic [2:0] kind);
    chk({req, " state"}, 32'(state), 32'(st));
    chk({req, " kind"}, 32'(rsp_kind), 32'(kind));
    chk({req, " valid"}, 32'(rsp_valid), 32'(kind != 3'd0));
  endtask

  task automatic publish();
    m_lfsr = lfsr_next(m_lfsr);
    m_rca  = m_lfsr;
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 state", 32'(state), 0);
    chk("R1 rca", 32'(rca), 0);
    chk("R1 valid", 32'(rsp_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].idx, VEC[i].arg);
      if (VEC[i].kind == 3'd3) publish();
      if (VEC[i].idx == 6'd0) m_rca = '0;
      expect_out($sformatf("R2-vec%0d", i), VEC[i].st, VEC[i].kind);
      chk($sformatf("R8 vec%0d rca", i), 32'(rca), 32'(m_rca));
    end

    // R3 busy card stays idle
    ocr = 32'h00FF_8000;
    send(6'd55, 0); send(6'd41, VW);
    expect_out("R3 busy", 3'd0, 3'd1);
    ocr = OCR_OK;

    send(6'd55, 0); send(6'd41, VW);
    expect_out("R3", 3'd1, 3'd1);
    send(6'd2, 0);
    expect_out("R5", 3'd2, 3'd2);
    send(6'd3, 0); publish();
    expect_out("R6", 3'd3, 3'd3);
    chk("R8 rca", 32'(rca), 32'(m_rca));
    chk("R8 nonzero", 32'(rca != 0), 1);
    rca_a = rca;
    send(6'd9, {rca_a, 16'h0});
    expect_out("R9 match", 3'd3, 3'd4);
    send(6'd9, {rca_a ^ 16'h0001, 16'h0});
    expect_out("R9 mismatch", 3'd3, 3'd0);
    send(6'd3, 0); publish();
    expect_out("R7 republish", 3'd3, 3'd3);
    chk("R7 new rca", 32'(rca), 32'(m_rca));
    chk("R7 differs", 32'(rca != rca_a), 1);
    send(6'd9, {rca_a, 16'h0});
    expect_out("R7 old rca", 3'd3, 3'd0);
    send(6'd9, {m_rca, 16'h0});
    expect_out("R7 new rca csd", 3'd3, 3'd4);

    send(6'd0, 0); m_rca = '0;
    expect_out("R10", 3'd0, 3'd0);
    chk("R10 rca", 32'(rca), 0);

    // R4 incompatible voltage
    send(6'd55, 0); send(6'd41, 32'h0000_0100);
    expect_out("R4", 3'd4, 3'd1);
    send(6'd0, 0);
    expect_out("R4 cmd0", 3'd4, 3'd0);
    send(6'd55, 0); send(6'd41, VW);
    expect_out("R4 query", 3'd4, 3'd0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset state", 32'(state), 0);
    chk("R1 re-reset rca", 32'(rca), 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule